// File: doc/BRIEF.md
# Serial Shift Unit

This block is the byte-wide serial shifter of a peripheral interface adapter. It owns a bit-clock pin and a bit-data pin, each with its own output-enable. A three-bit mode input picks the transfer direction and the source of the bit rate. The rate can come from the system clock, from a timer-underflow strobe, or from an external clock that arrives on the clock pin.

A bus write to the shift register starts an outgoing transfer, and a bus read starts an incoming one. When the unit drives the bit clock, it produces a symmetric clock that rests high. Outgoing data changes on the falling edges. Incoming data is sampled on the rising edges. After the eighth bit, a finish phase leaves the clock high, so a receiver can latch on the last rising edge. A done flag is raised when the eighth bit has been shifted. The free-running outgoing mode is the exception: it rotates the byte forever and never raises the flag.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, the bit clock output is high, the done flag is low, the shift register and the data output are zero, and both output-enables are low.
- R2: Mode codes are 000 off, 001 in at timer rate, 010 in at system clock, 011 in on external clock, 100 out free-running at timer rate, 101 out at timer rate, 110 out at system clock, 111 out on external clock. A write in any out mode loads the data, forces the bit clock high, clears the done flag and starts a transfer. A read in any in mode does the same, except that it loads no data.
- R3: Outgoing bits leave the most significant bit first, and each changes on a falling bit-clock edge. The register rotates left, so after a whole byte it holds the written value again.
- R4: Incoming bits are sampled on rising bit-clock edges and shifted left into bit 0. After a byte, the register holds the eight sampled bits, first bit in the most significant position.
- R5: A driven transfer makes exactly 8 falling and 8 rising bit-clock edges. The clock then stays high and stops toggling.
- R6: At system-clock rate, the first bit-clock fall comes one clock after the starting access. The done flag is first visible 15 clocks after the start edge for out and 16 clocks after it for in, on the eighth shifted bit.
- R7: At timer rate, each strobe toggles the bit clock once. The done flag rises with the 15th strobe for out and with the 16th for in.
- R8: The free-running out mode rotates the byte continuously and never raises the done flag. After 12 bits, the register holds the written byte rotated left by 4.
- R9: A read in an in mode during a transfer restarts it, and a full 8 bits follow.
- R10: In the external modes, the bit-clock output-enable is low. Each synchronised falling edge of the external clock shifts one bit out, and the done flag rises after the eighth.
- R11: In the off mode, a write loads the register and clears the flag, but the bit clock stays high and does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_mode | input | 3 | Transfer mode code |
| sr_wr | input | 1 | Bus write strobe for the shift register |
| sr_rd | input | 1 | Bus read strobe for the shift register |
| sr_wdata | input | W | Write data |
| sr_value | output | W | Current shift register contents |
| t2_strobe | input | 1 | Timer underflow strobe, one clock wide |
| sclk_in | input | 1 | External bit clock |
| sdat_in | input | 1 | Incoming serial data |
| sclk_out | output | 1 | Driven bit clock |
| sclk_oe | output | 1 | Output-enable for the bit clock |
| sdat_out | output | 1 | Outgoing serial data |
| sdat_oe | output | 1 | Output-enable for the data pin |
| sr_done | output | 1 | Shift-complete flag |

## Verification
A wrong sequencer state or counter value is visible at the pins within one byte. It shows up as a ninth or missing bit-clock edge, as a clock left low when the transfer ends, or as the done flag appearing one edge early or late. The latency from the start edge to the flag is pinned to the exact cycle at system-clock rate and to the exact strobe at timer rate, so an off-by-one in the counter or the finish phase fails on the first byte. Data-path faults show up as a bit-order mismatch on the data pin, or as a register value that differs from the written byte after a full rotation.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    SS_OFF      = 3'b000,
    SS_IN_T2    = 3'b001,
    SS_IN_SYS   = 3'b010,
    SS_IN_EXT   = 3'b011,
    SS_OUT_FREE = 3'b100,
    SS_OUT_T2   = 3'b101,
    SS_OUT_SYS  = 3'b110,
    SS_OUT_EXT  = 3'b111
  } ss_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SHIFT  = 2'd1,
    SQ_FINISH = 2'd2
  } ss_state_e;

  function automatic logic mode_is_out(input logic [2:0] m);
    return (m == SS_OUT_FREE) || (m == SS_OUT_T2) || (m == SS_OUT_SYS) || (m == SS_OUT_EXT);
  endfunction

  function automatic logic mode_is_in(input logic [2:0] m);
    return (m == SS_IN_T2) || (m == SS_IN_SYS) || (m == SS_IN_EXT);
  endfunction

  function automatic logic mode_is_ext(input logic [2:0] m);
    return (m == SS_IN_EXT) || (m == SS_OUT_EXT);
  endfunction

  function automatic logic mode_is_sys(input logic [2:0] m);
    return (m == SS_IN_SYS) || (m == SS_OUT_SYS);
  endfunction

  function automatic logic mode_is_t2(input logic [2:0] m);
    return (m == SS_IN_T2) || (m == SS_OUT_T2) || (m == SS_OUT_FREE);
  endfunction
endpackage

// File: rtl/ss_edge_src.sv
module ss_edge_src
  import ss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       active,
  input  logic       t2_strobe,
  input  logic       sclk_in,
  input  logic       sdat_in,
  output logic       int_tick,
  output logic       ext_rise,
  output logic       ext_fall,
  output logic       sdat_sync
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clk_pipe;
  logic [TOP:0] dat_pipe;
  logic         clk_last;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_pipe <= '1;
          dat_pipe <= '0;
        end else begin
          clk_pipe <= {clk_pipe[TOP-1:0], sclk_in};
          dat_pipe <= {dat_pipe[TOP-1:0], sdat_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_pipe <= '1;
          dat_pipe <= '0;
        end else begin
          clk_pipe <= sclk_in;
          dat_pipe <= sdat_in;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_last <= 1'b1;
    else     clk_last <= clk_pipe[TOP];
  end

  always_comb begin
    ext_rise  = clk_pipe[TOP] & ~clk_last;
    ext_fall  = ~clk_pipe[TOP] & clk_last;
    sdat_sync = dat_pipe[TOP];
    int_tick  = active & (mode_is_sys(mode) | (mode_is_t2(mode) & t2_strobe));
  end
endmodule

// File: rtl/ss_bitcnt.sv
module ss_bitcnt #(
  parameter int BITS = 8,
  localparam int CW  = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          at_one
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= CW'(BITS);
    else if (dec)  cnt <= cnt - CW'(1);
  end

  assign at_one = (cnt == CW'(1));
endmodule

// File: rtl/ss_shreg.sv
module ss_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shl_out,
  input  logic         shl_in,
  input  logic         in_bit,
  output logic [W-1:0] sr,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sr <= load_val;
    end else if (shl_out) begin
      dout <= sr[W-1];
      sr   <= {sr[W-2:0], sr[W-1]};
    end else if (shl_in) begin
      sr <= {sr[W-2:0], in_bit};
    end
  end
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ss_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   shift_mode,
  input  logic         sr_wr,
  input  logic         sr_rd,
  input  logic [W-1:0] sr_wdata,
  output logic [W-1:0] sr_value,
  input  logic         t2_strobe,
  input  logic         sclk_in,
  input  logic         sdat_in,
  output logic         sclk_out,
  output logic         sclk_oe,
  output logic         sdat_out,
  output logic         sdat_oe,
  output logic         sr_done
);
  ss_state_e     state_q;
  logic          cb1_q;
  logic          flag_q;
  logic          clk_oe_q;
  logic          dat_oe_q;
  logic [CW-1:0] bit_cnt;
  logic          at_one;

  logic int_tick, ext_rise, ext_fall, sdat_sync;
  logic is_ext, is_out, is_in;
  logic start_go, access;
  logic fall_ev, rise_ev, do_out, do_in, counting, last_bit;
  logic in_bit;

  ss_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .mode     (shift_mode),
    .active   (state_q != SQ_IDLE),
    .t2_strobe(t2_strobe),
    .sclk_in  (sclk_in),
    .sdat_in  (sdat_in),
    .int_tick (int_tick),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .sdat_sync(sdat_sync)
  );

  always_comb begin
    is_ext   = mode_is_ext(shift_mode);
    is_out   = mode_is_out(shift_mode);
    is_in    = mode_is_in(shift_mode);
    start_go = (sr_wr && is_out) || (sr_rd && is_in);
    access   = sr_wr || (sr_rd && is_in);
    fall_ev  = int_tick && cb1_q;
    rise_ev  = int_tick && !cb1_q;
    do_out   = (state_q == SQ_SHIFT) && is_out && (is_ext ? ext_fall : fall_ev);
    do_in    = (state_q == SQ_SHIFT) && is_in  && (is_ext ? ext_rise : rise_ev);
    counting = (do_out || do_in) && (shift_mode != SS_OUT_FREE);
    last_bit = counting && at_one;
    in_bit   = is_ext ? sdat_sync : sdat_in;
  end

  ss_bitcnt #(.BITS(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (access),
    .dec   (counting && !access),
    .cnt   (bit_cnt),
    .at_one(at_one)
  );

  ss_shreg #(.W(W)) u_sr (
    .clk     (clk),
    .rst     (rst),
    .load    (sr_wr),
    .load_val(sr_wdata),
    .shl_out (do_out && !access),
    .shl_in  (do_in && !access),
    .in_bit  (in_bit),
    .sr      (sr_value),
    .dout    (sdat_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      cb1_q    <= 1'b1;
      flag_q   <= 1'b0;
      clk_oe_q <= 1'b0;
      dat_oe_q <= 1'b0;
    end else begin
      clk_oe_q <= (shift_mode != SS_OFF) && !is_ext;
      dat_oe_q <= is_out;
      if (access) begin
        cb1_q   <= 1'b1;
        flag_q  <= 1'b0;
        state_q <= start_go ? SQ_SHIFT : SQ_IDLE;
      end else if (shift_mode == SS_OFF) begin
        cb1_q   <= 1'b1;
        state_q <= SQ_IDLE;
      end else begin
        case (state_q)
          SQ_SHIFT: begin
            if (int_tick) cb1_q <= ~cb1_q;
            if (last_bit) begin
              flag_q  <= 1'b1;
              state_q <= is_ext ? SQ_IDLE : SQ_FINISH;
            end
          end
          SQ_FINISH: begin
            if (int_tick) begin
              cb1_q   <= 1'b1;
              state_q <= SQ_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sclk_out = cb1_q;
  assign sclk_oe  = clk_oe_q;
  assign sdat_oe  = dat_oe_q;
  assign sr_done  = flag_q;
endmodule

// File: rtl/serial_shift_unit_chk.sv
module serial_shift_unit_chk
  import ss_pkg::*;
#(
  parameter int W   = 8,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    shift_mode,
  input logic          sr_wr,
  input logic          sclk_out,
  input logic          sclk_oe,
  input logic          sdat_out,
  input logic          sr_done,
  input logic [1:0]    state_q,
  input logic [CW-1:0] cnt_q
);
  // R5
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE) |-> sclk_out);

  // R6
  flag_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_done) |-> (cnt_q == '0));

  // R8
  freerun_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_mode == SS_OUT_FREE && $past(shift_mode) == SS_OUT_FREE) |-> !$rose(sr_done));

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_wr && shift_mode[2]) |=> (!sr_done && sclk_out && state_q == SQ_SHIFT));

  // R3
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && !$stable(sdat_out)) |-> $fell(sclk_out));

  // R10
  ext_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_mode[1:0] == 2'b11) |=> !sclk_oe);
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_mode(shift_mode),
  .sr_wr     (sr_wr),
  .sclk_out  (sclk_out),
  .sclk_oe   (sclk_oe),
  .sdat_out  (sdat_out),
  .sr_done   (sr_done),
  .state_q   (state_q),
  .cnt_q     (bit_cnt)
);

// File: tb/tb_serial_shift_unit.sv
`timescale 1ns/1ps
module tb_serial_shift_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] shift_mode = 3'b000;
  logic       sr_wr = 1'b0, sr_rd = 1'b0;
  logic [7:0] sr_wdata = '0;
  logic [7:0] sr_value;
  logic       t2_strobe = 1'b0, t2_en = 1'b0;
  logic       sclk_in = 1'b1, sdat_in = 1'b0;
  logic       sclk_out, sclk_oe, sdat_out, sdat_oe, sr_done;

  int checks = 0, errors = 0;
  int nfall = 0, nrise = 0;
  bit exp_q[$];
  bit in_q[$];

  always #2 clk = ~clk;

  serial_shift_unit dut (
    .clk(clk), .rst(rst), .shift_mode(shift_mode), .sr_wr(sr_wr), .sr_rd(sr_rd),
    .sr_wdata(sr_wdata), .sr_value(sr_value), .t2_strobe(t2_strobe),
    .sclk_in(sclk_in), .sdat_in(sdat_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdat_out(sdat_out), .sdat_oe(sdat_oe), .sr_done(sr_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: counts driven clock edges, compares outgoing bits
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && sclk_oe) begin
        if (prev && !sclk_out) begin
          nfall++;
          if (shift_mode[2] && exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check(sdat_out == e, "R3 bit order", sdat_out, e);
          end
        end
        if (!prev && sclk_out) nrise++;
      end
      prev = sclk_out;
    end
  end

  // timer underflow strobe source
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      t2_strobe = t2_en && (c % 4 == 0);
    end
  end

  task automatic run_xfer(input logic [2:0] m, input logic [7:0] d, input bit use_rd,
                          input int exp_lat, input bit t2, input string req);
    int n, f0, r0, nstb, flag_at, lat;
    logic prev;
    shift_mode = m;
    @(negedge clk); #1;
    exp_q.delete(); in_q.delete();
    for (int k = 0; k < 8; k++) begin
      if (m[2]) exp_q.push_back(d[7-k]);
      else      in_q.push_back(d[7-k]);
    end
    if (use_rd) sr_rd = 1'b1;
    else begin sr_wr = 1'b1; sr_wdata = d; end
    @(negedge clk); #1;
    sr_rd = 1'b0; sr_wr = 1'b0;
    f0 = nfall; r0 = nrise; nstb = int'(t2_strobe); n = 0; flag_at = -1;
    prev = sclk_out;
    check(sr_done == 1'b0 && sclk_out == 1'b1, {req, " R2 start clears"}, {sr_done, sclk_out}, 1);
    while (!(flag_at >= 0 && n > flag_at + 40) && n < 4000) begin
      @(negedge clk); #1;
      n++;
      if (n == 1 && !t2) check(sclk_out == 1'b0, "R6 first fall one clock after start", sclk_out, 0);
      if (prev && !sclk_out && !m[2] && in_q.size() > 0) sdat_in = in_q.pop_front();
      prev = sclk_out;
      if (sr_done && flag_at < 0) begin
        flag_at = n;
        lat = t2 ? nstb : n;
        check(lat == exp_lat, {req, " flag latency"}, lat, exp_lat);
        check((m[2] ? nfall - f0 : nrise - r0) == 8, "R6 flag on eighth bit",
              m[2] ? nfall - f0 : nrise - r0, 8);
      end
      nstb += int'(t2_strobe);
    end
    check(flag_at >= 0, {req, " flag raised"}, flag_at, 1);
    check(nfall - f0 == 8 && nrise - r0 == 8, "R5 edge count", (nfall - f0) * 16 + (nrise - r0), 8 * 16 + 8);
    check(sclk_out == 1'b1, "R5 clock rests high", sclk_out, 1);
    check(sr_value == d, m[2] ? "R3 register after rotation" : "R4 assembled byte", sr_value, d);
    if (m[2]) check(exp_q.size() == 0, "R3 all bits seen", exp_q.size(), 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check(sclk_out == 1'b1, "R1 clock high", sclk_out, 1);
    check(sr_done == 1'b0, "R1 flag low", sr_done, 0);
    check(sr_value == 8'h00, "R1 register zero", sr_value, 0);
    check(sdat_out == 1'b0, "R1 data zero", sdat_out, 0);
    check(sclk_oe == 1'b0 && sdat_oe == 1'b0, "R1 enables low", {sclk_oe, sdat_oe}, 0);

    // R11 off mode: write loads, no toggling
    begin
      int f0, r0;
      f0 = nfall; r0 = nrise;
      sr_wr = 1'b1; sr_wdata = 8'h3C;
      @(negedge clk); #1; sr_wr = 1'b0;
      repeat (20) @(negedge clk);
      #1;
      check(sr_value == 8'h3C, "R11 data loaded", sr_value, 8'h3C);
      check(sclk_out == 1'b1 && nfall == f0 && nrise == r0, "R11 no toggling", nfall - f0, 0);
    end

    // system-clock rate, R6
    run_xfer(3'b110, 8'hA5, 1'b0, 15, 1'b0, "R6 out sys");
    run_xfer(3'b110, 8'h01, 1'b0, 15, 1'b0, "R6 out sys");
    run_xfer(3'b010, 8'h6D, 1'b1, 16, 1'b0, "R4 in sys");

    // R9 read restart mid-transfer
    shift_mode = 3'b010;
    @(negedge clk); #1;
    sr_rd = 1'b1;
    @(negedge clk); #1; sr_rd = 1'b0;
    repeat (4) @(negedge clk);
    run_xfer(3'b010, 8'h96, 1'b1, 16, 1'b0, "R9 restart");

    // timer rate, R7
    t2_en = 1'b1;
    run_xfer(3'b101, 8'hC6, 1'b0, 15, 1'b1, "R7 out t2");
    run_xfer(3'b001, 8'h5B, 1'b1, 16, 1'b1, "R7 in t2");

    // R8 free-running rotation
    begin
      int n;
      shift_mode = 3'b100;
      @(negedge clk); #1;
      exp_q.delete();
      for (int k = 0; k < 12; k++) exp_q.push_back(bit'(8'hC3 >> (7 - (k % 8))));
      sr_wr = 1'b1; sr_wdata = 8'hC3;
      @(negedge clk); #1; sr_wr = 1'b0;
      n = 0;
      while (exp_q.size() > 0 && n < 2000) begin
        @(negedge clk); #1; n++;
      end
      check(exp_q.size() == 0, "R8 continuous rotation", exp_q.size(), 0);
      check(sr_value == 8'h3C, "R8 rotated by four", sr_value, 8'h3C);
      repeat (40) @(negedge clk);
      #1;
      check(sr_done == 1'b0, "R8 no flag", sr_done, 0);
      shift_mode = 3'b000;
      repeat (4) @(negedge clk);
    end
    t2_en = 1'b0;

    // R10 external clock, shift out
    begin
      logic [7:0] d;
      d = 8'h4E;
      shift_mode = 3'b111;
      @(negedge clk); #1;
      sr_wr = 1'b1; sr_wdata = d;
      @(negedge clk); #1; sr_wr = 1'b0;
      check(sclk_oe == 1'b0, "R10 clock undriven", sclk_oe, 0);
      for (int k = 0; k < 8; k++) begin
        sclk_in = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(sdat_out == d[7-k], "R10 external bit", sdat_out, d[7-k]);
        if (k == 6) check(sr_done == 1'b0, "R10 no early flag", sr_done, 0);
        sclk_in = 1'b1;
        repeat (5) @(negedge clk);
        #1;
      end
      check(sr_done == 1'b1, "R10 flag after eighth", sr_done, 1);
      check(sr_value == d, "R10 register restored", sr_value, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule